// File: doc/BRIEF.md
# CPU Address Window Decoder

This block sits between an 8-bit CPU's 16-bit address bus and the memories behind it. For each address it picks exactly one target region, raises that region's select line and gives the offset into the region. It also reports whether the access may write, flags a write that lands on a read-only window, and drives the fixed value 0xFF for any window that has nothing behind it. Three control inputs change the map. A boot overlay replaces the bottom 256 bytes with a small boot ROM. A cartridge-enable gates the two program ROM windows. A present flag says whether an external RAM sits in the banked RAM window.

The decoder is purely combinational and holds no state. All of its pins are plain control and status pins with no stream handshake: the CPU presents an address and strobe, and the selects settle in the same cycle. The memories, the bank-number logic and the IO register contents live outside the block.

Top module: `mem_window_decoder`

## Requirements
- R1: Exactly one bit of `region_sel` is high for every input combination. The bit order is 0 boot ROM, 1 ROM bank 0, 2 switchable ROM, 3 video RAM, 4 external RAM, 5 work RAM, 6 object attribute memory, 7 IO, 8 high RAM, 9 open (unmapped).
- R2: With `boot_ovl_en` high, 0x0000–0x00FF selects the boot ROM with offset equal to the address, read-only. The overlay takes priority over the cartridge ROM.
- R3: With `cart_en` high, 0x0000–0x3FFF (outside the overlay) selects ROM bank 0 with offset = address, and 0x4000–0x7FFF selects the switchable ROM with offset = address − 0x4000. Both are read-only.
- R4: With `cart_en` low, any address below 0x8000 that the overlay does not claim selects open.
- R5: 0x8000–0x9FFF selects video RAM, writable, with offset = address − 0x8000.
- R6: 0xA000–0xBFFF selects external RAM, writable, with offset = address − 0xA000, when `xram_present` is high. Otherwise it selects open.
- R7: 0xC000–0xDFFF selects work RAM with offset = address − 0xC000. 0xE000–0xFDFF also selects work RAM with offset = address − 0xE000. Both are writable.
- R8: 0xFE00–0xFE9F selects object attribute memory, writable, with offset = address − 0xFE00.
- R9: 0xFEA0–0xFEFF selects open.
- R10: 0xFF00–0xFF7F selects IO with offset = address − 0xFF00. 0xFF80–0xFFFF selects high RAM with offset = address − 0xFF80. Both are writable.
- R11: When open is selected, `open_data` is 0xFF, `wr_ok` is low and `region_off` is 0. When any other region is selected, `open_data` is 0x00.
- R12: `wr_fault` is high exactly when `cpu_wr` is high (1 = write) and `wr_ok` is low. A write to a read-only or open window therefore has no effect on any select or offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | Access strobe, 1 = write, 0 = read |
| boot_ovl_en | input | 1 | Boot ROM overlays the bottom 256 bytes |
| cart_en | input | 1 | Cartridge ROM windows are mapped |
| xram_present | input | 1 | External RAM exists in its window |
| region_sel | output | 10 | One-hot region select |
| region_off | output | 14 | Offset within the selected region |
| wr_ok | output | 1 | Selected region accepts writes |
| wr_fault | output | 1 | Write attempted to a read-only or open window |
| open_data | output | 8 | 0xFF while open is selected, else 0x00 |

## Verification
The block has no state, so every fault appears at the ports in the same cycle as the address that exposes it. A misplaced boundary shows up as the wrong select one address either side of that boundary. A wrong base shows up as an offset that is off by a constant. A wrong writable mask shows up as a `wr_ok`/`wr_fault` mismatch on the first write into that window. For this reason the stimulus tests each boundary and its neighbour under every combination of the four control inputs, and also sweeps the full address space once.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

  localparam int ADDR_W      = 16;
  localparam int OFF_W       = 14;
  localparam int DATA_W      = 8;
  localparam int NUM_REGIONS = 10;

  localparam int RG_BOOT = 0;
  localparam int RG_ROM0 = 1;
  localparam int RG_ROMX = 2;
  localparam int RG_VRAM = 3;
  localparam int RG_XRAM = 4;
  localparam int RG_WRAM = 5;
  localparam int RG_OAM  = 6;
  localparam int RG_IO   = 7;
  localparam int RG_HRAM = 8;
  localparam int RG_OPEN = 9;

  localparam logic [ADDR_W-1:0] LIM_BOOT = 16'h0100;
  localparam logic [ADDR_W-1:0] LIM_ROM0 = 16'h4000;
  localparam logic [ADDR_W-1:0] LIM_ROMX = 16'h8000;
  localparam logic [ADDR_W-1:0] LIM_VRAM = 16'hA000;
  localparam logic [ADDR_W-1:0] LIM_XRAM = 16'hC000;
  localparam logic [ADDR_W-1:0] LIM_ECHO = 16'hFE00;
  localparam logic [ADDR_W-1:0] LIM_OAM  = 16'hFEA0;
  localparam logic [ADDR_W-1:0] LIM_HOLE = 16'hFF00;
  localparam logic [ADDR_W-1:0] LIM_IO   = 16'hFF80;

  function automatic logic [ADDR_W-1:0] rg_base(input int r);
    case (r)
      RG_ROMX: return 16'h4000;
      RG_VRAM: return 16'h8000;
      RG_XRAM: return 16'hA000;
      RG_WRAM: return 16'hC000;
      RG_OAM:  return 16'hFE00;
      RG_IO:   return 16'hFF00;
      RG_HRAM: return 16'hFF80;
      default: return '0;
    endcase
  endfunction

  // Offset span mask; the work RAM mask also folds the upper mirror.
  function automatic logic [OFF_W-1:0] rg_mask(input int r);
    case (r)
      RG_BOOT, RG_OAM:          return 14'h00FF;
      RG_ROM0, RG_ROMX:         return 14'h3FFF;
      RG_VRAM, RG_XRAM, RG_WRAM: return 14'h1FFF;
      RG_IO, RG_HRAM:           return 14'h007F;
      default:                  return '0;
    endcase
  endfunction

  function automatic logic rg_writable(input int r);
    case (r)
      RG_VRAM, RG_XRAM, RG_WRAM, RG_OAM, RG_IO, RG_HRAM: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mwd_region_classify.sv
module mwd_region_classify
  import mwd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NR = NUM_REGIONS
) (
  input  logic [AW-1:0] addr,
  input  logic          boot_en,
  input  logic          cart_en,
  input  logic          xram_present,
  output logic [NR-1:0] sel
);
  int rg;

  always_comb begin
    if (boot_en && addr < LIM_BOOT)      rg = RG_BOOT;
    else if (addr < LIM_ROMX) begin
      if (!cart_en)                       rg = RG_OPEN;
      else if (addr < LIM_ROM0)           rg = RG_ROM0;
      else                                rg = RG_ROMX;
    end
    else if (addr < LIM_VRAM)             rg = RG_VRAM;
    else if (addr < LIM_XRAM)             rg = xram_present ? RG_XRAM : RG_OPEN;
    else if (addr < LIM_ECHO)             rg = RG_WRAM;
    else if (addr < LIM_OAM)              rg = RG_OAM;
    else if (addr < LIM_HOLE)             rg = RG_OPEN;
    else if (addr < LIM_IO)               rg = RG_IO;
    else                                  rg = RG_HRAM;
  end

  for (genvar i = 0; i < NR; i++) begin : g_sel
    assign sel[i] = (rg == i);
  end
endmodule

// File: rtl/mwd_offset_gen.sv
module mwd_offset_gen
  import mwd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W,
  parameter int NR = NUM_REGIONS
) (
  input  logic [AW-1:0] addr,
  input  logic [NR-1:0] sel,
  output logic [OW-1:0] off
);
  logic [OW-1:0] cand [NR];

  for (genvar i = 0; i < NR; i++) begin : g_cand
    localparam logic [AW-1:0] BASE = rg_base(i);
    localparam logic [OW-1:0] MASK = rg_mask(i);
    logic [AW-1:0] diff;
    assign diff    = addr - BASE;
    assign cand[i] = diff[OW-1:0] & MASK;
  end

  always_comb begin
    off = '0;
    for (int i = 0; i < NR; i++)
      if (sel[i]) off = off | cand[i];
  end
endmodule

// File: rtl/mwd_access_policy.sv
module mwd_access_policy
  import mwd_pkg::*;
#(
  parameter int NR = NUM_REGIONS,
  parameter int DW = DATA_W
) (
  input  logic [NR-1:0] sel,
  input  logic          wr,
  output logic          wr_ok,
  output logic          wr_fault,
  output logic [DW-1:0] open_data
);
  logic [NR-1:0] wmask;

  for (genvar i = 0; i < NR; i++) begin : g_wmask
    assign wmask[i] = rg_writable(i);
  end

  assign wr_ok     = |(sel & wmask);
  assign wr_fault  = wr & ~wr_ok;
  assign open_data = sel[RG_OPEN] ? {DW{1'b1}} : '0;
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import mwd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W,
  parameter int DW = DATA_W,
  parameter int NR = NUM_REGIONS
) (
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic          boot_ovl_en,
  input  logic          cart_en,
  input  logic          xram_present,
  output logic [NR-1:0] region_sel,
  output logic [OW-1:0] region_off,
  output logic          wr_ok,
  output logic          wr_fault,
  output logic [DW-1:0] open_data
);
  mwd_region_classify #(.AW(AW), .NR(NR)) u_classify (
    .addr(cpu_addr), .boot_en(boot_ovl_en), .cart_en(cart_en),
    .xram_present(xram_present), .sel(region_sel)
  );

  mwd_offset_gen #(.AW(AW), .OW(OW), .NR(NR)) u_offset (
    .addr(cpu_addr), .sel(region_sel), .off(region_off)
  );

  mwd_access_policy #(.NR(NR), .DW(DW)) u_policy (
    .sel(region_sel), .wr(cpu_wr), .wr_ok(wr_ok),
    .wr_fault(wr_fault), .open_data(open_data)
  );
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker
  import mwd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W,
  parameter int DW = DATA_W,
  parameter int NR = NUM_REGIONS
) (
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_wr,
  input logic [NR-1:0] region_sel,
  input logic [OW-1:0] region_off,
  input logic          wr_ok,
  input logic          wr_fault,
  input logic [DW-1:0] open_data
);
  logic known;
  logic [AW-1:0] wram_rel;

  assign known    = !$isunknown({cpu_addr, cpu_wr});
  assign wram_rel = (cpu_addr >= 16'hE000) ? cpu_addr - 16'hE000 : cpu_addr - 16'hC000;

  always_comb begin
    if (known) begin
      p_onehot_r1: assert ($onehot(region_sel)) else $error("p_onehot_r1");
      p_boot_ro_r2: assert (!region_sel[RG_BOOT] || (!wr_ok && cpu_addr < 16'h0100))
        else $error("p_boot_ro_r2");
      p_rom_ro_r3: assert (!(region_sel[RG_ROM0] || region_sel[RG_ROMX]) || !wr_ok)
        else $error("p_rom_ro_r3");
      p_mirror_off_r7: assert (!region_sel[RG_WRAM] || region_off == wram_rel[OW-1:0])
        else $error("p_mirror_off_r7");
      p_hole_r9: assert (!(cpu_addr >= 16'hFEA0 && cpu_addr < 16'hFF00) || region_sel[RG_OPEN])
        else $error("p_hole_r9");
      p_open_r11: assert (region_sel[RG_OPEN] ? (open_data == {DW{1'b1}} && !wr_ok && region_off == '0)
                                              : (open_data == '0))
        else $error("p_open_r11");
      p_fault_r12: assert (!wr_fault || (cpu_wr && !wr_ok)) else $error("p_fault_r12");
    end
  end
endmodule

bind mem_window_decoder mwd_checker #(.AW(AW), .OW(OW), .DW(DW), .NR(NR)) u_mwd_checker (
  .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .region_sel(region_sel),
  .region_off(region_off), .wr_ok(wr_ok), .wr_fault(wr_fault), .open_data(open_data)
);

// File: tb/mem_window_decoder_bench.sv
module mem_window_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] cpu_addr = '0;
  logic cpu_wr = 1'b0, boot_ovl_en = 1'b0, cart_en = 1'b0, xram_present = 1'b0;
  logic [9:0]  region_sel;
  logic [13:0] region_off;
  logic        wr_ok, wr_fault;
  logic [7:0]  open_data;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  mem_window_decoder u_mem_window_decoder (
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .boot_ovl_en(boot_ovl_en),
    .cart_en(cart_en), .xram_present(xram_present), .region_sel(region_sel),
    .region_off(region_off), .wr_ok(wr_ok), .wr_fault(wr_fault), .open_data(open_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v, input int a);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%0h expected=%0h", req, a, act, exp_v);
    end
  endtask

  // Behavioural reference: region index per bit order of R1.
  task automatic model(input int a, input bit boot, input bit cart, input bit xr,
                       output int rg, output int off, output string tag);
    if (boot && a < 256) begin rg = 0; off = a; tag = "R2"; end
    else if (a < 'h8000) begin
      if (!cart) begin rg = 9; off = 0; tag = "R4"; end
      else if (a < 'h4000) begin rg = 1; off = a; tag = "R3"; end
      else begin rg = 2; off = a - 'h4000; tag = "R3"; end
    end
    else if (a < 'hA000) begin rg = 3; off = a - 'h8000; tag = "R5"; end
    else if (a < 'hC000) begin
      if (xr) begin rg = 4; off = a - 'hA000; end else begin rg = 9; off = 0; end
      tag = "R6";
    end
    else if (a < 'hE000) begin rg = 5; off = a - 'hC000; tag = "R7"; end
    else if (a < 'hFE00) begin rg = 5; off = a - 'hE000; tag = "R7"; end
    else if (a < 'hFEA0) begin rg = 6; off = a - 'hFE00; tag = "R8"; end
    else if (a < 'hFF00) begin rg = 9; off = 0; tag = "R9"; end
    else if (a < 'hFF80) begin rg = 7; off = a - 'hFF00; tag = "R10"; end
    else begin rg = 8; off = a - 'hFF80; tag = "R10"; end
  endtask

  task automatic apply(input int a, input bit boot, input bit cart, input bit xr, input bit wr);
    int rg, off, od;
    bit wok, wf;
    string tag;
    @(posedge clk); #1;
    cpu_addr = a[15:0]; boot_ovl_en = boot; cart_en = cart; xram_present = xr; cpu_wr = wr;
    @(negedge clk);
    model(a, boot, cart, xr, rg, off, tag);
    wok = (rg >= 3 && rg <= 8);
    od  = (rg == 9) ? 'hFF : 0;
    wf  = wr && !wok;
    chk($countones(region_sel) == 1, "R1", int'(region_sel), 1 << rg, a);
    chk(region_sel == 10'(1 << rg), tag, int'(region_sel), 1 << rg, a);
    chk(int'(region_off) == off, (rg == 9) ? "R11" : tag, int'(region_off), off, a);
    chk(wr_ok == wok, (rg == 9) ? "R11" : tag, int'(wr_ok), int'(wok), a);
    chk(int'(open_data) == od, "R11", int'(open_data), od, a);
    chk(wr_fault == wf, "R12", int'(wr_fault), int'(wf), a);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  int bounds[12] = '{'h0000, 'h0100, 'h4000, 'h8000, 'hA000, 'hC000,
                     'hE000, 'hFE00, 'hFEA0, 'hFF00, 'hFF80, 'hFFFF};

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-state check: all controls low, address zero -> open (R4, R11).
    @(negedge clk);
    chk(region_sel == 10'b10_0000_0000, "R4", int'(region_sel), 'h200, 0);
    chk(open_data == 8'hFF, "R11", int'(open_data), 'hFF, 0);
    // Boundary sweep under every control combination (R2..R10).
    for (int c = 0; c < 16; c++) begin
      for (int b = 0; b < 12; b++) begin
        if (bounds[b] > 0) apply(bounds[b] - 1, c[0], c[1], c[2], c[3]);
        apply(bounds[b], c[0], c[1], c[2], c[3]);
        apply(bounds[b] + ((bounds[b] < 'hFFFF) ? 1 : 0), c[0], c[1], c[2], c[3]);
      end
    end
    // Full address sweep, mirror and holes included (R7, R9, R12).
    for (int a = 0; a < 65536; a++)
      apply(a, 1'b1, 1'b1, a[1], a[0]);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule